// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Access Controller

This block sits between a synchronous request port and an asynchronous 16-bit static RAM with a 19-bit word address. It takes one read or write at a time, then drives the memory strobes through a fixed sequence. The strobes are a low-true and a high-true chip select, a low-true write strobe, a low-true output enable, and one low-true enable for each byte lane. When the sequence is complete, the block reports the result with a one-cycle done pulse.

Each analogue timing interval of the memory is given in nanoseconds, together with the clock period. The block converts every interval to a whole number of clock cycles, rounding up. A single down-counter then paces the phases of each access.

The memory data bus is split into three signals: an input, an output and a driver enable. During a write, the driver turns on only after the memory has had time to release the bus. It turns off one cycle after the write strobe rises. Reads mask away any lane that was not requested.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, both chip selects are inactive (`mem_ce_n`=1, `mem_ce`=0), `mem_we_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` are 1, `mem_dq_oe` is 0, `rsp_done` is 0 and `req_ready` is 1.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no access is in progress. A request presented while an access is in progress is dropped and never reaches the memory.
- R3: From the accepting edge until the access ends, `mem_addr` equals the accepted address, `mem_ce_n` is 0 and `mem_ce` is 1. With no access in progress, the memory is deselected.
- R4: A write has three phases. First, one setup cycle with `mem_we_n` high. Next, `mem_we_n` is low for max(ceil(pulse), ceil(float)+ceil(data setup), ceil(address-to-end) - 1) cycles, which is 5 at the defaults. Last, one recovery cycle. `rsp_done` is high for exactly one cycle, starting 7 edges after the accepting edge at the defaults, and the block is ready again in that same cycle.
- R5: `req_mask` bit 0 selects data bits 7:0 through `mem_lb_n`, and bit 1 selects bits 15:8 through `mem_ub_n`. A lane that is not selected keeps its stored contents. A mask of 0 leaves both lane enables high, so nothing is written.
- R6: Throughout a write, `mem_oe_n` stays high. `mem_dq_oe` rises only after `mem_we_n` has been low for ceil(float) cycles (2 at the defaults), and it falls one cycle after `mem_we_n` rises. Driven data is held at least the data-setup time before the write ends, and the write window lasts at least the minimum pulse time.
- R7: A read holds `mem_we_n` high and `mem_oe_n` low, with lanes enabled per `req_mask`. Data is sampled once the strobes have been asserted for max(ceil(read cycle), ceil(address-to-data), ceil(enable-to-data)) cycles, which is 6 at the defaults. `rsp_done` is a one-cycle pulse starting 6 edges after the accepting edge, and `rsp_rdata` is valid while it is high.
- R8: In read data, a byte lane that was not requested returns zero, whatever the memory drives.
- R9: `mem_dq_oe` is never high while `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select: bit 0 low byte, bit 1 high byte |
| req_ready | output | 1 | Idle and able to accept a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unrequested lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Low-true chip select |
| mem_ce | output | 1 | High-true chip select |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_ub_n | output | 1 | Low-true upper lane enable |
| mem_lb_n | output | 1 | Low-true lower lane enable |
| mem_dq_in | input | 16 | Data from memory |
| mem_dq_out | output | 16 | Data to memory |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
The assertions assume that `req_addr` and the other request fields matter only on the accepting edge. They also assume that `mem_dq_in` is sampled only as data and never feeds back into the strobes. Two further assumptions are that reset is held for at least one edge and that `req_valid` is driven away from the clock edge. The stimulus meets these assumptions: it changes every input on the falling edge and lowers `req_valid` right after the accepting edge. It raises `req_valid` during a busy access only to test that the request is dropped. The memory model puts deliberate filler on disabled lanes, so any masking error shows up in the read data.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_CAPT,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOV
  } ctrl_state_e;

  typedef struct packed {
    logic ce_n;
    logic ce;
    logic we_n;
    logic oe_n;
    logic ub_n;
    logic lb_n;
  } strobe_t;

  localparam strobe_t STB_IDLE = '{ce_n: 1'b1, ce: 1'b0, we_n: 1'b1,
                                   oe_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1};

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R4: a reloaded count never wraps while running down
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/sram_dq_driver.sv
module sram_dq_driver #(
  parameter int CNT_W   = 8,
  parameter int FLOAT_C = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we_n_now,
  input  logic we_n_next,
  output logic dq_oe
);

  localparam logic [CNT_W-1:0] FLOAT_LIM = CNT_W'(FLOAT_C);

  logic [CNT_W-1:0] low_cnt_q, low_cnt_d;
  logic             oe_q, oe_d;

  always_comb begin
    if (we_n_now)                 low_cnt_d = '0;
    else if (low_cnt_q < FLOAT_LIM) low_cnt_d = low_cnt_q + 1'b1;
    else                          low_cnt_d = low_cnt_q;
    oe_d = (!we_n_next && (low_cnt_d >= FLOAT_LIM)) ||
           (!we_n_now && we_n_next);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      low_cnt_q <= low_cnt_d;
      oe_q      <= oe_d;
    end
  end

  assign dq_oe = oe_q;

  // R6: driver is on only while the write strobe is low or in the cycle after it rose
  p_drive_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (!we_n_now || $past(!we_n_now)));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 8,
  parameter int CLK_NS    = 10,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_DOE_NS  = 25,
  parameter int T_WC_NS   = 55,
  parameter int T_PWE_NS  = 40,
  parameter int T_AW_NS   = 40,
  parameter int T_SD_NS   = 25,
  parameter int T_SA_NS   = 0,
  parameter int T_HZWE_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  localparam int LANES = DATA_W / 8;
  localparam int RD_C  = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                              ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int SU_C  = imax(1, ns_to_cyc(T_SA_NS, CLK_NS));
  localparam int FL_C  = ns_to_cyc(T_HZWE_NS, CLK_NS);
  localparam int PW_C  = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), FL_C + ns_to_cyc(T_SD_NS, CLK_NS)),
                              ns_to_cyc(T_AW_NS, CLK_NS) - SU_C);
  localparam int RV_C  = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - SU_C - PW_C);

  ctrl_state_e state_q, state_d;
  strobe_t     stb_q, stb_d;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q, mask_d;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q, done_d;
  logic              accept, capture;
  logic              tmr_load, tmr_expired;
  logic [CNT_W-1:0]  tmr_val;

  assign accept  = req_valid && (state_q == ST_IDLE);
  assign capture = (state_q == ST_RD_WAIT) && tmr_expired;
  assign mask_d  = accept ? req_mask : mask_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid)   state_d = req_write ? ST_WR_SETUP : ST_RD_WAIT;
      ST_RD_WAIT:  if (tmr_expired) state_d = ST_RD_CAPT;
      ST_RD_CAPT:                   state_d = ST_IDLE;
      ST_WR_SETUP: if (tmr_expired) state_d = ST_WR_PULSE;
      ST_WR_PULSE: if (tmr_expired) state_d = ST_WR_RECOV;
      ST_WR_RECOV: if (tmr_expired) state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  // phase length loaded on every state change
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_RD_WAIT:  tmr_val = CNT_W'(RD_C - 1);
      ST_WR_SETUP: tmr_val = CNT_W'(SU_C - 1);
      ST_WR_PULSE: tmr_val = CNT_W'(PW_C - 1);
      ST_WR_RECOV: tmr_val = CNT_W'(RV_C - 1);
      default:     tmr_val = '0;
    endcase
  end

  // strobe decode from the next state
  always_comb begin
    stb_d = STB_IDLE;
    if (state_d != ST_IDLE && state_d != ST_RD_CAPT) begin
      stb_d.ce_n = 1'b0;
      stb_d.ce   = 1'b1;
      stb_d.lb_n = ~mask_d[0];
      stb_d.ub_n = ~mask_d[LANES-1];
      stb_d.oe_n = (state_d != ST_RD_WAIT);
      stb_d.we_n = (state_d != ST_WR_PULSE);
    end
  end

  assign done_d = capture || ((state_q == ST_WR_RECOV) && tmr_expired);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stb_q   <= STB_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= stb_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q[g*8 +: 8] <= '0;
      else if (capture) rdata_q[g*8 +: 8] <= mask_q[g] ? mem_dq_in[g*8 +: 8] : 8'h00;
    end
  end

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_dq_driver #(.CNT_W(CNT_W), .FLOAT_C(FL_C)) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_n_now  (stb_q.we_n),
    .we_n_next (stb_d.we_n),
    .dq_oe     (mem_dq_oe)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_ce_n   = stb_q.ce_n;
  assign mem_ce     = stb_q.ce;
  assign mem_we_n   = stb_q.we_n;
  assign mem_oe_n   = stb_q.oe_n;
  assign mem_ub_n   = stb_q.ub_n;
  assign mem_lb_n   = stb_q.lb_n;

  // R2: an accepted request leaves the idle state at once
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3: idle means deselected
  p_idle_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n));

  // R3: address held through a busy access
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

  // R6: output enable stays off while writing
  p_oe_off_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R7: done lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R9: no driving against a memory that may be driving
  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int T_AA = 55, T_RC = 55, T_DOE = 25, T_WC = 55;
  localparam int T_PWE = 40, T_AW = 40, T_SD = 25, T_HZWE = 20;

  function automatic int cyc(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [18:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n;
  logic [15:0] mem_dq_in, mem_dq_out;
  logic        mem_dq_oe;

  int checks = 0, errors = 0;

  sram_lane_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n),
    .mem_lb_n(mem_lb_n), .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- memory model ----------------
  logic [15:0] ram [256];
  logic sel, win, rd_active;
  longint t_drive_on = 0, t_win_on = 0, t_rd_on = 0;
  int setup_viol = 0, pulse_viol = 0, nodata_viol = 0, early_viol = 0;
  int contention = 0, oe_in_write = 0;

  assign sel       = !mem_ce_n && mem_ce;
  assign win       = sel && !mem_we_n && (!mem_ub_n || !mem_lb_n);
  assign rd_active = sel && !mem_oe_n && mem_we_n;
  assign mem_dq_in = rd_active ?
    {mem_ub_n ? 8'hA5 : ram[mem_addr[7:0]][15:8], mem_lb_n ? 8'h5A : ram[mem_addr[7:0]][7:0]} :
    16'h3C3C;

  always @(posedge mem_dq_oe) t_drive_on = $time;
  always @(posedge win)       t_win_on   = $time;
  always @(posedge rd_active) t_rd_on    = $time;

  always @(negedge win) begin
    if (!mem_dq_oe) nodata_viol++;
    if ($time - t_drive_on < T_SD) setup_viol++;
    if ($time - t_win_on < T_PWE) pulse_viol++;
    if (!mem_lb_n) ram[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
    if (!mem_ub_n) ram[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
  end

  always @(posedge rsp_done) if (!req_write && ($time - t_rd_on < T_AA)) early_viol++;

  always @(negedge clk) begin
    if (mem_dq_oe && !mem_oe_n) contention++;
    if (!mem_we_n && !mem_oe_n) oe_in_write++;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [18:0] a, input logic [15:0] d,
                      input logic [1:0] m, input bit poke,
                      output int lat, output int we_low, output logic [15:0] rd,
                      output bit sel_ok);
    int n;
    while (!req_ready) @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; we_low = 0; sel_ok = 1'b1;
    while (!rsp_done && n < 100) begin
      if (!mem_we_n) we_low++;
      if (mem_addr != a || mem_ce_n || !mem_ce) sel_ok = 1'b0;
      if (poke && n == 2) begin
        req_write = 1'b1; req_addr = 19'h00055; req_wdata = 16'hFFFF;
        req_mask = 2'b11; req_valid = 1'b1;
      end
      if (poke && n == 3) begin req_valid = 1'b0; req_write = wr; end
      @(negedge clk);
      n++;
    end
    lat = n;
    rd  = rsp_rdata;
    @(negedge clk);
    chk(!rsp_done, "R7 done single cycle", rsp_done, 0);
  endtask

  localparam int EXP_RD = mx(mx(cyc(T_RC), cyc(T_AA)), cyc(T_DOE));
  localparam int EXP_SU = 1;
  localparam int EXP_PW = mx(mx(cyc(T_PWE), cyc(T_HZWE) + cyc(T_SD)), cyc(T_AW) - EXP_SU);
  localparam int EXP_RV = mx(1, cyc(T_WC) - EXP_SU - EXP_PW);

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(mem_ce_n && !mem_ce, "R1 chip selects idle", {mem_ce_n, mem_ce}, 2'b10);
    chk(mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n, "R1 strobes idle",
        {mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}, 4'hF);
    chk(!mem_dq_oe && !rsp_done && req_ready, "R1 driver/done/ready",
        {mem_dq_oe, rsp_done, req_ready}, 3'b001);
  endtask

  task automatic t_full_write_read();
    int lat, wl; logic [15:0] rd; bit ok;
    xfer(1'b1, 19'h40011, 16'hBEEF, 2'b11, 1'b0, lat, wl, rd, ok);
    chk(lat == EXP_SU + EXP_PW + EXP_RV, "R4 write latency", lat, EXP_SU + EXP_PW + EXP_RV);
    chk(wl == EXP_PW, "R4 write strobe cycles", wl, EXP_PW);
    chk(ok, "R3 address and selects held (write)", ok, 1);
    chk(req_ready, "R4 ready with write done", req_ready, 1);
    xfer(1'b0, 19'h40011, 16'h0000, 2'b11, 1'b0, lat, wl, rd, ok);
    chk(lat == EXP_RD, "R7 read latency", lat, EXP_RD);
    chk(wl == 0, "R7 write strobe idle in read", wl, 0);
    chk(rd == 16'hBEEF, "R7 read data", rd, 16'hBEEF);
    chk(ok, "R3 address and selects held (read)", ok, 1);
  endtask

  task automatic t_lane_write();
    int lat, wl; logic [15:0] rd; bit ok;
    xfer(1'b1, 19'h00022, 16'h1234, 2'b01, 1'b0, lat, wl, rd, ok);
    xfer(1'b0, 19'h00022, 16'h0000, 2'b11, 1'b0, lat, wl, rd, ok);
    chk(rd == 16'h1034, "R5 lower lane only", rd, 16'h1034);
    xfer(1'b1, 19'h12333, 16'hAB99, 2'b10, 1'b0, lat, wl, rd, ok);
    xfer(1'b0, 19'h12333, 16'h0000, 2'b11, 1'b0, lat, wl, rd, ok);
    chk(rd == 16'hAB33, "R5 upper lane only", rd, 16'hAB33);
    xfer(1'b1, 19'h00044, 16'hFFFF, 2'b00, 1'b0, lat, wl, rd, ok);
    xfer(1'b0, 19'h00044, 16'h0000, 2'b11, 1'b0, lat, wl, rd, ok);
    chk(rd == 16'h1044, "R5 empty mask writes nothing", rd, 16'h1044);
  endtask

  task automatic t_lane_read();
    int lat, wl; logic [15:0] rd; bit ok;
    xfer(1'b0, 19'h40011, 16'h0000, 2'b01, 1'b0, lat, wl, rd, ok);
    chk(rd == 16'h00EF, "R8 upper lane zero", rd, 16'h00EF);
    xfer(1'b0, 19'h40011, 16'h0000, 2'b10, 1'b0, lat, wl, rd, ok);
    chk(rd == 16'hBE00, "R8 lower lane zero", rd, 16'hBE00);
    xfer(1'b0, 19'h40011, 16'h0000, 2'b00, 1'b0, lat, wl, rd, ok);
    chk(rd == 16'h0000, "R8 no lanes", rd, 16'h0000);
  endtask

  task automatic t_busy_ignore();
    int lat, wl; logic [15:0] rd; bit ok;
    xfer(1'b0, 19'h40011, 16'h0000, 2'b11, 1'b1, lat, wl, rd, ok);
    chk(lat == EXP_RD && rd == 16'hBEEF, "R2 busy read unaffected", rd, 16'hBEEF);
    xfer(1'b0, 19'h00055, 16'h0000, 2'b11, 1'b0, lat, wl, rd, ok);
    chk(rd == 16'h1055, "R2 busy request dropped", rd, 16'h1055);
  endtask

  task automatic t_bus_rules();
    chk(setup_viol == 0, "R6 data setup before write end", setup_viol, 0);
    chk(pulse_viol == 0, "R6 write window width", pulse_viol, 0);
    chk(nodata_viol == 0, "R6 driver on at write end", nodata_viol, 0);
    chk(oe_in_write == 0, "R6 output enable high in write", oe_in_write, 0);
    chk(early_viol == 0, "R7 sample after access time", early_viol, 0);
    chk(contention == 0, "R9 no bus contention", contention, 0);
  endtask

  task automatic t_float_delay();
    int n, first_on, we_fall;
    while (!req_ready) @(negedge clk);
    req_write = 1'b1; req_addr = 19'h00066; req_wdata = 16'h5566; req_mask = 2'b11;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; first_on = -1; we_fall = -1;
    while (!rsp_done && n < 100) begin
      if (!mem_we_n && we_fall < 0) we_fall = n;
      if (mem_dq_oe && first_on < 0) first_on = n;
      @(negedge clk);
      n++;
    end
    chk(first_on - we_fall == cyc(T_HZWE), "R6 driver delay after strobe falls",
        first_on - we_fall, cyc(T_HZWE));
    chk(!mem_dq_oe, "R6 driver off after recovery", mem_dq_oe, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 16'h1000 + 16'(i);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_write_read();
    t_lane_write();
    t_lane_read();
    t_busy_ignore();
    t_float_delay();
    t_bus_rules();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule